// File: doc/BRIEF.md
# Host Frame Injection Assembler

This block turns a host's register-level frame injection sequence into a byte-qualified word stream. The host has two write ports. One is a 32-bit control port, and its flags open and close a frame. The other is a 32-bit data port, and each write on it appends one word. A frame is written in this order:

1. A start control write, which also carries an inter-frame gap size.
2. A fixed number of header words.
3. The payload words, zero-padded by the host to a minimum cell when the frame is short.
4. An end control write, which carries a valid-byte count for the final payload word.
5. One trailing placeholder checksum word.

The end marker arrives after the last payload word has already been written. The block therefore holds each payload word for one write until it knows whether that word is the last one. It then emits the word with a last flag and a byte-enable mask, and it drops the placeholder checksum word. Header words leave on the same stream with a header qualifier set. The gap size is latched per frame and shown as sideband. A sticky error flag reports protocol misuse: data outside a frame, a start inside an open frame, or an end with no payload.

The output stream has no back-pressure. Each accepted write produces at most one output beat, one clock after the write.

Top module: `inj_frame_asm`

## Requirements
- R1: While reset is held low and after it is released, `out_valid` is 0 and `err` is 0 until a write arrives.
- R2: A control write with bit 18 set opens a frame, whether or not bit 19 is also set. The next HDR_WORDS data writes are each output one clock later with `out_hdr`=1, `out_last`=0 and `out_keep`=4'b1111.
- R3: A payload data write (any write after the header words) is held back. The held word is output with `out_hdr`=0, `out_last`=0 and `out_keep`=4'b1111 one clock after the next payload data write.
- R4: An end control write (bit 19 set, bit 18 clear) in an open frame with a held payload word outputs that word one clock later with `out_last`=1. Its `out_keep` comes from bits 17:16, byte 0 at the LSB: 0 gives 4'b1111, 1 gives 4'b0001, 2 gives 4'b0011, 3 gives 4'b0111.
- R5: The first data write after an end control write is the placeholder checksum word. It produces no output and closes the frame.
- R6: Each of the following sets `err`, which then stays 1 until reset:
  - a data write with no frame open;
  - a start write while a frame is open or awaiting its checksum word;
  - an end write with no held payload word.

  In each case the held payload word is discarded without being output. A start write still opens the new frame; an empty end write closes the frame.
- R7: Bits 23:21 of a start write are latched and shown on `out_gap` from the clock after that write until the next start write.
- R8: When a control write and a data write arrive in the same cycle, the control write takes effect first. For example, an end write and the checksum word together emit the last word once, and a start write and a data write together make that data the first header word.
- R9: A control write with neither bit 18 nor bit 19 set, or an end write when no frame is open, has no effect: no output and no change of `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control word: start bit 18, end bit 19, valid bytes 17:16, gap 23:21 |
| dat_we | input | 1 | Data write strobe |
| dat_wdata | input | 32 | Data word |
| out_valid | output | 1 | Output beat present |
| out_data | output | 32 | Output word |
| out_keep | output | 4 | Byte enables, bit 0 = byte 0 |
| out_last | output | 1 | Final payload word of a frame |
| out_hdr | output | 1 | Beat is a header word |
| out_gap | output | GAP_W | Gap size latched at the frame start |
| err | output | 1 | Sticky protocol error |

## Verification
The two functions that can land in the same cycle are a control write and a data write. The cases of interest are an end write together with the checksum word, a start write together with the first header word, and a start write together with a payload word inside an open frame. The bench issues these pairs both as directed cases and at random, with both strobes raised in one cycle. A bench model applies the control write before the data write and predicts every output beat and the error flag. The check is that exactly one beat, or none, appears one clock later with the predicted data, qualifiers and mask.

// File: rtl/inj_frame_asm.sv
module inj_frame_asm #(
  parameter int HDR_WORDS = 2,
  parameter int GAP_W     = 3,
  parameter int SOF_BIT   = 18,
  parameter int EOF_BIT   = 19,
  parameter int VB_LSB    = 16,
  parameter int GAP_LSB   = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  input  logic             dat_we,
  input  logic [31:0]      dat_wdata,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic [3:0]       out_keep,
  output logic             out_last,
  output logic             out_hdr,
  output logic [GAP_W-1:0] out_gap,
  output logic             err
);
  localparam int HCW = $clog2(HDR_WORDS + 2);
  localparam logic [HCW-1:0] HDR_INIT = HCW'(HDR_WORDS);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_OPEN = 2'd1, S_CRC = 2'd2} st_t;

  st_t              st_q, st_n;
  logic [HCW-1:0]   hl_q, hl_n;
  logic             hv_q, hv_n;
  logic [31:0]      hold_q, hold_n;
  logic [GAP_W-1:0] gap_q, gap_n;
  logic             err_q, err_n;
  logic             ov_n, ol_n, oh_n;
  logic [31:0]      od_n;
  logic [3:0]       ok_n;

  wire       is_sof = ctl_wdata[SOF_BIT];
  wire       is_eof = ctl_wdata[EOF_BIT];
  wire [1:0] vb     = ctl_wdata[VB_LSB +: 2];
  wire [3:0] vb_keep = (vb == 2'd0) ? 4'b1111 : 4'((5'd1 << vb) - 5'd1);

  always_comb begin
    st_n = st_q; hl_n = hl_q; hv_n = hv_q; hold_n = hold_q;
    gap_n = gap_q; err_n = err_q;
    ov_n = 1'b0; od_n = hold_q; ok_n = 4'b1111; ol_n = 1'b0; oh_n = 1'b0;

    if (ctl_we) begin
      if (is_sof) begin
        if (st_n != S_IDLE) err_n = 1'b1;
        st_n  = S_OPEN;
        hl_n  = HDR_INIT;
        hv_n  = 1'b0;
        gap_n = ctl_wdata[GAP_LSB +: GAP_W];
      end else if (is_eof && st_n == S_OPEN) begin
        if (hv_n) begin
          ov_n = 1'b1; od_n = hold_q; ok_n = vb_keep; ol_n = 1'b1;
          st_n = S_CRC;
        end else begin
          err_n = 1'b1;
          st_n  = S_IDLE;
        end
        hv_n = 1'b0;
      end
    end

    if (dat_we) begin
      case (st_n)
        S_IDLE: err_n = 1'b1;
        S_CRC:  st_n  = S_IDLE;
        default: begin
          if (hl_n != '0) begin
            ov_n = 1'b1; od_n = dat_wdata; oh_n = 1'b1;
            hl_n = hl_n - 1'b1;
          end else begin
            if (hv_n) begin
              ov_n = 1'b1; od_n = hold_q;
            end
            hold_n = dat_wdata;
            hv_n   = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; hl_q <= '0; hv_q <= 1'b0; hold_q <= '0;
      gap_q <= '0; err_q <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_keep <= 4'b1111;
      out_last <= 1'b0; out_hdr <= 1'b0;
    end else begin
      st_q <= st_n; hl_q <= hl_n; hv_q <= hv_n; hold_q <= hold_n;
      gap_q <= gap_n; err_q <= err_n;
      out_valid <= ov_n; out_data <= od_n; out_keep <= ok_n;
      out_last <= ol_n; out_hdr <= oh_n;
    end
  end

  assign out_gap = gap_q;
  assign err     = err_q;
endmodule

module inj_frame_asm_chk #(
  parameter int GAP_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [31:0]      ctl_wdata,
  input logic             dat_we,
  input logic [1:0]       st,
  input logic             out_valid,
  input logic [3:0]       out_keep,
  input logic             out_last,
  input logic             out_hdr,
  input logic [GAP_W-1:0] out_gap,
  input logic             err
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R6
  AST_IDLE_DATA_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !ctl_we && st == 2'd0) |=> err); // R6
  AST_HDR_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hdr) |-> (!out_last && out_keep == 4'b1111)); // R2
  AST_MID_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> out_keep == 4'b1111); // R3
  AST_KEEP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_keep == 4'b0001 || out_keep == 4'b0011 ||
                   out_keep == 4'b0111 || out_keep == 4'b1111)); // R4
  AST_CRC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && dat_we && !ctl_we) |=> !out_valid); // R5
  AST_GAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_we && ctl_wdata[18]) |=> $stable(out_gap)); // R7
  AST_NOFLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[18] && !ctl_wdata[19] && !dat_we) |=> !out_valid); // R9
endmodule

bind inj_frame_asm inj_frame_asm_chk #(.GAP_W(GAP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .dat_we(dat_we), .st(st_q), .out_valid(out_valid), .out_keep(out_keep),
  .out_last(out_last), .out_hdr(out_hdr), .out_gap(out_gap), .err(err)
);

// File: tb/inj_frame_asm_tb_top.sv
module inj_frame_asm_tb_top;
  localparam int HDR = 2;
  localparam int GW  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, dat_we = 1'b0;
  logic [31:0] ctl_wdata = '0, dat_wdata = '0;
  logic out_valid, out_last, out_hdr, err;
  logic [31:0] out_data;
  logic [3:0] out_keep;
  logic [GW-1:0] out_gap;

  always #2 clk = ~clk;

  inj_frame_asm #(.HDR_WORDS(HDR), .GAP_W(GW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .out_valid(out_valid),
    .out_data(out_data), .out_keep(out_keep), .out_last(out_last),
    .out_hdr(out_hdr), .out_gap(out_gap), .err(err));

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string ctx = "R1";

  int m_st, m_hl;
  bit m_hv, m_err;
  logic [31:0] m_hold;
  logic [GW-1:0] m_gap;
  bit e_v, e_l, e_h;
  logic [31:0] e_d;
  logic [3:0] e_k;

  function automatic logic [3:0] kmap(input logic [1:0] v);
    case (v)
      2'd1: return 4'b0001;
      2'd2: return 4'b0011;
      2'd3: return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] mk_ctl(bit sof, bit eof, logic [1:0] v, logic [2:0] g);
    return {8'h0, g, 1'b0, eof, sof, v, 16'h0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s (case %s) actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  task automatic m_reset();
    m_st = 0; m_hl = 0; m_hv = 0; m_err = 0; m_hold = '0; m_gap = '0;
  endtask

  task automatic m_step(input bit cw, input logic [31:0] cd, input bit dw, input logic [31:0] dd);
    e_v = 0; e_l = 0; e_h = 0; e_k = 4'b1111; e_d = '0;
    if (cw) begin
      if (cd[18]) begin
        if (m_st != 0) m_err = 1;
        m_st = 1; m_hl = HDR; m_hv = 0; m_gap = cd[23:21];
      end else if (cd[19] && m_st == 1) begin
        if (m_hv) begin
          e_v = 1; e_d = m_hold; e_l = 1; e_k = kmap(cd[17:16]); m_st = 2;
        end else begin
          m_err = 1; m_st = 0;
        end
        m_hv = 0;
      end
    end
    if (dw) begin
      if (m_st == 0) m_err = 1;
      else if (m_st == 2) m_st = 0;
      else if (m_hl > 0) begin
        e_v = 1; e_d = dd; e_h = 1; m_hl--;
      end else begin
        if (m_hv) begin e_v = 1; e_d = m_hold; end
        m_hold = dd; m_hv = 1;
      end
    end
  endtask

  task automatic cyc(input bit cw, input logic [31:0] cd, input bit dw, input logic [31:0] dd);
    @(negedge clk);
    ctl_we = cw; ctl_wdata = cd; dat_we = dw; dat_wdata = dd;
    m_step(cw, cd, dw, dd);
    @(posedge clk);
    #1;
    check(out_valid == e_v, "R3", 32'(out_valid), 32'(e_v));
    check(err == m_err, "R6", 32'(err), 32'(m_err));
    if (e_v && out_valid) begin
      check(out_data == e_d, "R3", out_data, e_d);
      check(out_hdr == e_h, "R2", 32'(out_hdr), 32'(e_h));
      check(out_last == e_l, "R4", 32'(out_last), 32'(e_l));
      check(out_keep == e_k, "R4", 32'(out_keep), 32'(e_k));
      check(out_gap == m_gap, "R7", 32'(out_gap), 32'(m_gap));
    end
    @(negedge clk);
    ctl_we = 0; dat_we = 0;
  endtask

  task automatic idle(); cyc(0, '0, 0, '0); endtask
  task automatic ctl(input logic [31:0] c); cyc(1, c, 0, '0); endtask
  task automatic dat(input logic [31:0] d); cyc(0, '0, 1, d); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ctl_we = 0; dat_we = 0;
    repeat (3) @(posedge clk);
    #1;
    ctx = "R1";
    check(out_valid == 0, "R1", 32'(out_valid), 0);
    check(err == 0, "R1", 32'(err), 0);
    @(negedge clk);
    rst_n = 1;
    m_reset();
    idle();
  endtask

  task automatic rand_frame();
    int np = 1 + int'($urandom_range(0, 20));
    logic [2:0] g = 3'($urandom);
    logic [1:0] v = 2'($urandom);
    bit pair = ($urandom_range(0, 3) == 0);
    if ($urandom_range(0, 2) == 0) cyc(1, mk_ctl(1, 0, 0, g), 1, $urandom);
    else begin
      ctl(mk_ctl(1, 0, 0, g));
      for (int i = 0; i < HDR; i++) dat($urandom);
    end
    if ($urandom_range(0, 2) == 0) dat($urandom);
    for (int i = 0; i < np; i++) begin
      if ($urandom_range(0, 5) == 0) idle();
      if ($urandom_range(0, 12) == 0) ctl(mk_ctl(0, 0, 2'($urandom), 0));
      dat($urandom);
    end
    if (np < 15) begin
      for (int i = np; i < 15; i++) dat(32'h0);
      v = 2'd0;
    end
    if (pair) cyc(1, mk_ctl(0, 1, v, 0), 1, 32'hC0C0C0C0);
    else begin
      ctl(mk_ctl(0, 1, v, 0));
      dat(32'hC0C0C0C0);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd13));
    m_reset();
    do_reset();

    ctx = "R2";
    ctl(mk_ctl(1, 0, 0, 3'd5));
    dat(32'hAAAA0001); dat(32'hAAAA0002);
    ctx = "R3";
    dat(32'h11111111); dat(32'h22222222); dat(32'h33333333);
    ctx = "R9";
    ctl(mk_ctl(0, 0, 2'd3, 3'd1));
    check(out_valid == 0, "R9", 32'(out_valid), 0);
    ctx = "R4";
    ctl(mk_ctl(0, 1, 2'd2, 0));
    check(out_keep == 4'b0011 && out_last, "R4", 32'(out_keep), 32'h3);
    ctx = "R5";
    dat(32'hDEADBEEF);
    check(out_valid == 0, "R5", 32'(out_valid), 0);
    ctx = "R9";
    ctl(mk_ctl(0, 1, 2'd1, 0));
    check(out_valid == 0 && err == 0, "R9", 32'(out_valid), 0);

    for (int vv = 0; vv < 4; vv++) begin
      ctx = "R4";
      ctl(mk_ctl(1, 1, 0, 3'(vv)));
      dat(1); dat(2); dat(32'h5A5A0000 + vv);
      ctl(mk_ctl(0, 1, 2'(vv), 0));
      check(out_keep == kmap(2'(vv)), "R4", 32'(out_keep), 32'(kmap(2'(vv))));
      check(out_gap == 3'(vv), "R7", 32'(out_gap), vv);
      dat(0);
    end

    ctx = "R8";
    cyc(1, mk_ctl(1, 0, 0, 3'd2), 1, 32'h0000BEEF);
    check(out_hdr == 1 && out_data == 32'hBEEF, "R8", out_data, 32'hBEEF);
    dat(7); dat(8); dat(9);
    cyc(1, mk_ctl(0, 1, 2'd1, 0), 1, 32'hC0C0C0C0);
    check(out_data == 32'd9 && out_last, "R8", out_data, 9);
    idle();
    check(out_valid == 0, "R8", 32'(out_valid), 0);

    ctx = "R6";
    ctl(mk_ctl(1, 0, 0, 3'd3));
    dat(1); dat(2); dat(3);
    cyc(1, mk_ctl(1, 0, 0, 3'd4), 1, 32'h77);
    check(err == 1, "R6", 32'(err), 1);
    dat(4); dat(5);
    ctl(mk_ctl(0, 1, 0, 0)); dat(0);
    idle();
    check(err == 1, "R6", 32'(err), 1);

    do_reset();
    ctx = "R6";
    dat(32'h1234);
    check(err == 1 && out_valid == 0, "R6", 32'(err), 1);
    do_reset();
    ctl(mk_ctl(1, 0, 0, 0)); dat(1); dat(2);
    ctl(mk_ctl(0, 1, 0, 0));
    check(err == 1 && out_valid == 0, "R6", 32'(err), 1);

    do_reset();
    ctx = "R8";
    for (int f = 0; f < 300; f++) begin
      rand_frame();
      if ($urandom_range(0, 3) == 0) idle();
    end
    ctx = "R6";
    for (int f = 0; f < 100; f++) begin
      if ($urandom_range(0, 9) == 0) dat($urandom);
      if ($urandom_range(0, 9) == 0) begin
        ctl(mk_ctl(1, 0, 0, 3'($urandom))); dat($urandom);
      end
      rand_frame();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule